// File: doc/BRIEF.md
# External Interrupt Flag Controller

A four-channel front end that turns asynchronous interrupt pins into sticky request flags for a downstream interrupt controller. Each pin is first passed through a synchroniser. The block then checks it against a per-channel sense setting, which is either a level or an edge of a chosen polarity. When the condition occurs, the channel's flag is set. Each flag drives its own request line. The OR of all flags forms a wake indication for power-management logic.

Software reaches the block through a plain register port. The port has a select, a write strobe, an address and write data. Read data is combinational from the address, and there is no valid/ready handshake because the port carries control traffic only. The flag register is cleared by writing ones. In level mode, a clear only takes effect when the pin is inactive. The synchroniser stages and the edge-history flop reset to logic high. With the reset configuration (level, active-low), idle-high pins therefore raise no flag when reset is released.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the flag register (offset 0x0), the mode register (offset 0x8) and the polarity register (offset 0xC) read 0x00, and `irq` and `wake` are low.
- R2: In level mode (mode bit = 0), a channel's flag is set while its pin is at the active level: high when the polarity bit is 1, low when it is 0.
- R3: In edge mode (mode bit = 1), a channel's flag is set by a rising pin edge when the polarity bit is 1, or by a falling edge when it is 0. An edge in the other direction leaves the flag unchanged.
- R4: Writing offset 0x0 clears each flag bit whose write-data bit is 1. Data bits that are 0 leave their flags unchanged. A set flag otherwise stays set.
- R5: In level mode, a clear written while the pin is still active leaves the flag set. A clear written after the pin has returned to the inactive level clears it.
- R6: If a qualifying edge and a write-one clear act on the same channel in the same cycle, the flag ends up set.
- R7: `irq[i]` equals flag bit i, and `wake` is high exactly when any flag is set.
- R8: Mode and polarity occupy bits [3:0] at offsets 0x8 and 0xC and read back as written. Bits [7:4] of every read are zero. Unmapped offsets read 0x00.
- R9: Each channel's flag depends only on its own pin, mode bit and polarity bit.
- R10: A pin change made between two clock edges appears on `irq` after the third rising clock edge, and not after the second (two synchroniser stages plus the flag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous interrupt pins, one per channel |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 4 | Per-channel interrupt request (flag state) |
| wake | output | 1 | OR of all flags |

## Verification
Several properties are checked on every cycle:
- a set flag never drops without a clear;
- a level-mode channel at its active level is set on the next cycle;
- an edge that coincides with a clear still leaves the flag set;
- reserved read bits stay zero, and a mode write shows up in the register.

Only the directed scenarios can show the rest:
- the exact three-edge latency from pin to request;
- that the wrong edge direction is ignored;
- that a level clear succeeds once the pin has gone inactive;
- that channels do not disturb each other;
- the decoding of the register offsets.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_FLAG = 4'h0;
  localparam logic [OFS_W-1:0] OFS_MODE = 4'h8;
  localparam logic [OFS_W-1:0] OFS_POL  = 4'hC;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extint_channel.sv
module extint_channel
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o
);
  logic pin_d_q;
  logic flag_q;
  logic level_hit;
  logic edge_hit;
  logic set_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d_q <= 1'b1;
    else        pin_d_q <= pin_s_i;
  end

  always_comb begin
    level_hit = (pin_s_i == pol_i);
    edge_hit  = (pin_s_i != pin_d_q) && (pin_s_i == pol_i);
    set_now   = (sense_e'(mode_i) == SENSE_EDGE) ? edge_hit : level_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  assert_level_blocks_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && (pin_s_i == pol_i)) |=> flag_q);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && clr_i && (pin_s_i != pin_d_q) && (pin_s_i == pol_i)) |=> flag_q);

  assert_edge_quiet_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && clr_i && (pin_s_i == pin_d_q)) |=> !flag_q);
endmodule

// File: rtl/extint_regfile.sv
module extint_regfile
  import extint_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_CH-1:0] flags_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] pol_q;
  logic              wr_en;
  logic              hit_flag, hit_mode, hit_pol;

  assign wr_en    = bus_sel && bus_wr;
  assign hit_flag = (bus_addr == ADDR_W'(OFS_FLAG));
  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_pol  = (bus_addr == ADDR_W'(OFS_POL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (hit_mode) mode_q <= bus_wdata[NUM_CH-1:0];
      if (hit_pol)  pol_q  <= bus_wdata[NUM_CH-1:0];
    end
  end

  assign clr_o  = (wr_en && hit_flag) ? bus_wdata[NUM_CH-1:0] : '0;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_flag)      bus_rdata[NUM_CH-1:0] = flags_i;
    else if (hit_mode) bus_rdata[NUM_CH-1:0] = mode_q;
    else if (hit_pol)  bus_rdata[NUM_CH-1:0] = pol_q;
  end

  generate
    if (NUM_CH < DATA_W) begin : g_reserved
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CH];

      assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_CH] == '0);
    end
  endgenerate

  assert_mode_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_mode) |=> (mode_o == $past(bus_wdata[NUM_CH-1:0])));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              wake
);
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] mode;
  logic [NUM_CH-1:0] pol;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] flags;

  extint_regfile #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags_i   (flags),
    .bus_rdata (bus_rdata),
    .mode_o    (mode),
    .pol_o     (pol),
    .clr_o     (clr)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      extint_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
      ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i[ch]),
        .q_o   (pin_s[ch])
      );

      extint_channel chan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pin_s[ch]),
        .mode_i  (mode[ch]),
        .pol_i   (pol[ch]),
        .clr_i   (clr[ch]),
        .flag_o  (flags[ch])
      );
    end
  endgenerate

  assign irq  = flags;
  assign wake = |flags;

  assert_wake_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == '0) |-> !wake);
endmodule

// File: tb/extint_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_i = 4'hF;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] irq;
  logic       wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  extint_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .wake      (wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(4'h0, 8'h00, "R1 flag reset");
    rd_chk(4'h8, 8'h00, "R1 mode reset");
    rd_chk(4'hC, 8'h00, "R1 polarity reset");
    chk(irq == 4'h0 && wake == 1'b0, "R1 irq/wake reset", {irq, 3'b0, wake}, 0);
  endtask

  task automatic t_regs;
    wr(4'h8, 8'hFF);
    rd_chk(4'h8, 8'h0F, "R8 mode readback, reserved zero");
    wr(4'hC, 8'hA5);
    rd_chk(4'hC, 8'h05, "R8 polarity readback, reserved zero");
    rd_chk(4'h4, 8'h00, "R8 unmapped offset");
    wr(4'hC, 8'h00);
    cycles(4);
    rd_chk(4'h0, 8'h00, "R9 no flags from config change");
  endtask

  task automatic t_edge_fall;
    @(negedge clk); pin_i[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(irq[0] == 1'b0, "R10 not after second edge", irq, 0);
    @(negedge clk);
    chk(irq[0] == 1'b1, "R10 after third edge / R3 falling", irq, 1);
    chk(irq[3:1] == 3'b000, "R9 other channels idle", irq, 1);
    pin_i[0] = 1'b1;
    cycles(4);
    chk(irq[0] == 1'b1, "R4 flag sticky", irq, 1);
    wr(4'h0, 8'h01);
    chk(irq[0] == 1'b0, "R4 write-one clears", irq, 0);
    pin_i[0] = 1'b0; cycles(4);
    wr(4'h0, 8'h01);
    pin_i[0] = 1'b1; cycles(4);
    chk(irq[0] == 1'b0, "R3 rising ignored with falling polarity", irq, 0);
  endtask

  task automatic t_edge_rise;
    wr(4'hC, 8'h02);
    pin_i[1] = 1'b0; cycles(4);
    chk(irq[1] == 1'b0, "R3 falling ignored with rising polarity", irq, 0);
    pin_i[1] = 1'b1; cycles(4);
    chk(irq == 4'h2, "R3 rising sets flag", irq, 2);
    chk(wake == 1'b1, "R7 wake with flag set", wake, 1);
    wr(4'h0, 8'h00);
    rd_chk(4'h0, 8'h02, "R4 writing zero has no effect");
    wr(4'h0, 8'hFD);
    rd_chk(4'h0, 8'h02, "R4 clear of other bits leaves flag");
    wr(4'h0, 8'h02);
    chk(irq == 4'h0 && wake == 1'b0, "R7 wake low after clear", {irq, wake}, 0);
  endtask

  task automatic t_level;
    wr(4'hC, 8'h06);
    pin_i[2] = 1'b0; cycles(4);
    wr(4'h8, 8'h0B);
    cycles(4);
    chk(irq[2] == 1'b0, "R2 inactive level no flag", irq, 0);
    pin_i[2] = 1'b1; cycles(4);
    chk(irq[2] == 1'b1, "R2 active-high level sets", irq, 4);
    wr(4'h0, 8'h04);
    chk(irq[2] == 1'b1, "R5 clear blocked while active", irq, 4);
    pin_i[2] = 1'b0; cycles(4);
    chk(irq[2] == 1'b1, "R5 flag held after pin inactive", irq, 4);
    wr(4'h0, 8'h04);
    chk(irq[2] == 1'b0, "R5 clear after inactive", irq, 0);
    wr(4'h8, 8'h03);
    cycles(3);
    chk(irq == 4'h0, "R9 no spurious flag on mode change", irq, 0);
    pin_i[3] = 1'b0; cycles(4);
    chk(irq == 4'h8, "R2 active-low level sets", irq, 8);
    wr(4'h0, 8'h08);
    chk(irq[3] == 1'b1, "R5 active-low clear blocked", irq, 8);
    pin_i[3] = 1'b1; cycles(4);
    wr(4'h0, 8'h08);
    chk(irq == 4'h0, "R5 active-low clear after release", irq, 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk); pin_i[0] = 1'b0;
    cycles(4);
    pin_i[0] = 1'b1; cycles(4);
    chk(irq[0] == 1'b1, "R6 precondition flag set", irq, 1);
    pin_i[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 8'h01;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    chk(irq[0] == 1'b1, "R6 edge wins over same-cycle clear", irq, 1);
    wr(4'h0, 8'h01);
    chk(irq[0] == 1'b0, "R6 later clear succeeds", irq, 0);
    pin_i[0] = 1'b1; cycles(3);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_regs();
    wr(4'h8, 8'h0F);
    t_edge_fall();
    t_edge_rise();
    t_level();
    t_set_wins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule